// File: doc/BRIEF.md
# Disk Attention and Status Register Pair

This block is the host-facing register front of a small disk controller. It decodes two byte-wide locations on a simple strobe bus. The control location reads back a status byte. Writing to it stores a control byte for the controller engine. The attention location reads back an interrupt-status byte. Writing to it latches an attention nibble that tells the engine which operation the host wants.

Two side effects carry the protocol. A control write with its top bit set raises a flag in the status byte. A nonzero attention nibble puts the status byte into a fixed busy pattern. Reading the interrupt-status byte acknowledges the pending interrupt by clearing bit 1, and the host still sees the value from before the clear.

The data transfer and command engines sit outside this block. A per-bit set input stands in for them, so that interrupt conditions can be raised on demand. The interrupt line follows bit 1 of the interrupt-status byte.

Top module: `dsk_attn_regs`

## Requirements
- R1: While reset is high, every register clears on each clock edge: status, interrupt status, control, attention and read data all become 0x00, and irq is low.
- R2: A write strobe at the control address stores the full write byte, and ctrl_out shows it after that clock edge.
- R3: A control write whose bit 7 is 1 ORs 0x02 into the status byte and leaves its other bits unchanged. A control write whose bit 7 is 0 leaves the status byte unchanged.
- R4: A write strobe at the attention address latches only bits 7:4 of the write byte. attn_out shows those bits in bits 7:4, and its bits 3:0 are always 0.
- R5: An attention write whose bits 7:4 are nonzero loads the status byte with exactly 0x14. An attention write whose bits 7:4 are zero leaves the status byte unchanged.
- R6: A read strobe at the control address puts the status byte on rdata after that clock edge and changes no register.
- R7: A read strobe at the attention address puts the interrupt-status byte held before the edge on rdata. On the same edge it clears bit 1 of that byte and leaves the other bits unchanged.
- R8: Each bit of isr_set that is high at a clock edge sets the matching interrupt-status bit. For bit 1, a set wins over a clear-on-read in the same cycle.
- R9: irq is high exactly while interrupt-status bit 1 is 1.
- R10: A read strobe at any address other than the two mapped ones returns 0xFF on rdata.
- R11: rdata holds its value in every cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address (control at CTRL_ADDR, attention at ATTN_ADDR) |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data, valid the cycle after rd_en |
| isr_set | input | DW | Per-bit set of the interrupt-status byte, from the engine |
| ctrl_out | output | DW | Stored control byte |
| attn_out | output | DW | Latched attention value, low half always zero |
| irq | output | 1 | Interrupt request, follows interrupt-status bit 1 |

## Verification
The assertions check, on every cycle, the port-level behaviour:
- the control byte and attention nibble are captured on writes;
- the low half of the attention value stays zero;
- unmapped reads return 0xFF, and rdata holds between reads;
- irq drops after an acknowledging read unless a set arrives in the same cycle, and rises on a set;
- all outputs return to zero under reset.

The status byte and the pre-clear read value are not visible on their own, so only the bench scenarios show them. The scenarios cover these orderings:
- OR-ing of the control flag into a busy pattern;
- a zero attention nibble that leaves the status alone;
- reading the interrupt-status byte before its bit 1 clears;
- a set that collides with an acknowledging read.

// File: rtl/dskreg_pkg.sv
package dskreg_pkg;
  // status byte values
  localparam logic [7:0] STAT_BUSY     = 8'h14;
  localparam logic [7:0] STAT_CTRL_FLG = 8'h02;
  // interrupt-status bit acknowledged by read, drives irq
  localparam int unsigned ISR_ACK_BIT  = 1;
  // read value for unmapped addresses
  localparam logic [7:0] RD_UNMAPPED   = 8'hFF;
endpackage

// File: rtl/dsk_addr_dec.sv
module dsk_addr_dec #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter logic [ADDR_W-1:0] ATTN_ADDR = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              ctrl_we,
  output logic              attn_we,
  output logic              ctrl_re,
  output logic              attn_re
);
  logic hit_ctrl, hit_attn;

  always_comb begin
    hit_ctrl = (addr == CTRL_ADDR);
    hit_attn = (addr == ATTN_ADDR);
    ctrl_we  = wr_en && hit_ctrl;
    attn_we  = wr_en && hit_attn;
    ctrl_re  = rd_en && hit_ctrl;
    attn_re  = rd_en && hit_attn;
  end
endmodule

// File: rtl/dsk_status_reg.sv
module dsk_status_reg
  import dskreg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic          attn_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] attn_q
);
  localparam int unsigned HALF    = DW / 2;
  localparam logic [DW-1:0] HI_MASK = {{(DW-HALF){1'b1}}, {HALF{1'b0}}};
  localparam logic [DW-1:0] BUSY    = DW'(STAT_BUSY);
  localparam logic [DW-1:0] FLAG    = DW'(STAT_CTRL_FLG);

  logic nib_nz;
  assign nib_nz = |wdata[DW-1:HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ctrl_q   <= '0;
      attn_q   <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata;
      if (wdata[DW-1]) status_q <= status_q | FLAG;
    end else if (attn_we) begin
      attn_q <= wdata & HI_MASK;
      if (nib_nz) status_q <= BUSY;
    end
  end
endmodule

// File: rtl/dsk_isr_reg.sv
module dsk_isr_reg
  import dskreg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_rd,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] isr_q,
  output logic          irq
);
  localparam logic [DW-1:0] ACK_MASK = DW'(1) << ISR_ACK_BIT;

  logic [DW-1:0] isr_d;

  always_comb begin
    isr_d = isr_q;
    if (ack_rd) isr_d = isr_d & ~ACK_MASK;
    isr_d = isr_d | set_bits;   // set wins over clear-on-read
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= isr_d;
  end

  assign irq = isr_q[ISR_ACK_BIT];
endmodule

// File: rtl/dsk_attn_regs.sv
module dsk_attn_regs
  import dskreg_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter logic [ADDR_W-1:0] ATTN_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     isr_set,
  output logic [DW-1:0]     ctrl_out,
  output logic [DW-1:0]     attn_out,
  output logic              irq
);
  localparam logic [DW-1:0] UNMAPPED = DW'(RD_UNMAPPED);

  logic ctrl_we, attn_we, ctrl_re, attn_re;
  logic [DW-1:0] status_q, isr_q;

  dsk_addr_dec #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ATTN_ADDR(ATTN_ADDR)) dec_i (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .ctrl_we(ctrl_we), .attn_we(attn_we), .ctrl_re(ctrl_re), .attn_re(attn_re)
  );

  dsk_status_reg #(.DW(DW)) stat_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .attn_we(attn_we), .wdata(wdata),
    .status_q(status_q), .ctrl_q(ctrl_out), .attn_q(attn_out)
  );

  dsk_isr_reg #(.DW(DW)) isr_i (
    .clk(clk), .rst(rst), .ack_rd(attn_re), .set_bits(isr_set),
    .isr_q(isr_q), .irq(irq)
  );

  // read data register: returns value held before any clear-on-read
  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (ctrl_re) rdata <= status_q;
    else if (attn_re) rdata <= isr_q;
    else if (rd_en)   rdata <= UNMAPPED;
  end
endmodule

// File: rtl/dsk_attn_regs_chk.sv
module dsk_attn_regs_chk #(
  parameter int unsigned DW     = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
  parameter logic [ADDR_W-1:0] ATTN_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [DW-1:0]     isr_set,
  input logic [DW-1:0]     ctrl_out,
  input logic [DW-1:0]     attn_out,
  input logic              irq
);
  localparam int unsigned HALF = DW / 2;
  localparam logic [DW-1:0] HI_MASK = {{(DW-HALF){1'b1}}, {HALF{1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rdata == '0 && ctrl_out == '0 && attn_out == '0 && !irq));

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR) |=> ctrl_out == $past(wdata));

  // R4
  attn_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ATTN_ADDR) |=> attn_out == ($past(wdata) & HI_MASK));

  // R4
  attn_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    attn_out[HALF-1:0] == '0);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ATTN_ADDR && !isr_set[1]) |=> !irq);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    isr_set[1] |=> irq);

  // R9
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(isr_set[1]));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != CTRL_ADDR && addr != ATTN_ADDR) |=> rdata == '1);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind dsk_attn_regs dsk_attn_regs_chk #(
  .DW(DW), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ATTN_ADDR(ATTN_ADDR)
) chk_i (.*);

// File: tb/dsk_attn_regs_tb_top.sv
module dsk_attn_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h2;
  localparam logic [ADDR_W-1:0] A_ATTN = 4'h4;
  localparam logic [ADDR_W-1:0] A_NONE = 4'h0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0, isr_set = '0;
  logic [DW-1:0] rdata, ctrl_out, attn_out;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsk_attn_regs #(.DW(DW), .ADDR_W(ADDR_W), .CTRL_ADDR(A_CTRL), .ATTN_ADDR(A_ATTN)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .isr_set(isr_set), .ctrl_out(ctrl_out), .attn_out(attn_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read result actual=%h expected=none", rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", rdata, 8'h00);
    check("R1 ctrl_out", ctrl_out, 8'h00);
    check("R1 attn_out", attn_out, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(A_CTRL, 8'h00, "R1 status after reset");
    rd(A_ATTN, 8'h00, "R1 isr after reset");

    // R2 / R3: bit7 clear leaves status
    wr(A_CTRL, 8'h35);
    check("R2 ctrl_out", ctrl_out, 8'h35);
    rd(A_CTRL, 8'h00, "R3 no flag without bit7");

    // R3 flag set; R6 read has no side effect
    wr(A_CTRL, 8'h81);
    check("R2 ctrl_out", ctrl_out, 8'h81);
    rd(A_CTRL, 8'h02, "R3 flag set");
    rd(A_CTRL, 8'h02, "R6 status read repeat");

    // R4 / R5 zero nibble
    wr(A_ATTN, 8'h0F);
    check("R4 attn_out low nibble discarded", attn_out, 8'h00);
    rd(A_CTRL, 8'h02, "R5 zero nibble keeps status");

    // R5 nonzero nibble
    wr(A_ATTN, 8'hA7);
    check("R4 attn_out", attn_out, 8'hA0);
    rd(A_CTRL, 8'h14, "R5 busy pattern");

    // R3 OR preserves other bits
    wr(A_CTRL, 8'h80);
    rd(A_CTRL, 8'h16, "R3 OR into busy");

    // R8 / R9 / R7
    isr_set = 8'h06;
    @(negedge clk);
    isr_set = 8'h00;
    check("R9 irq set", {7'd0, irq}, 8'h01);
    rd(A_ATTN, 8'h06, "R7 pre-clear value");
    check("R9 irq after ack", {7'd0, irq}, 8'h00);
    rd(A_ATTN, 8'h04, "R7 bit1 cleared only");

    // R8 set wins over simultaneous clear
    isr_set = 8'h02;
    rd(A_ATTN, 8'h04, "R8 read during set");
    isr_set = 8'h00;
    check("R8 irq kept", {7'd0, irq}, 8'h01);
    rd(A_ATTN, 8'h06, "R8 bit1 retained");
    rd(A_ATTN, 8'h04, "R7 cleared again");

    // R10 / R11
    rd(A_NONE, 8'hFF, "R10 unmapped");
    @(negedge clk);
    check("R11 rdata hold", rdata, 8'hFF);
    check("R2 ctrl_out unchanged by reads", ctrl_out, 8'h80);

    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule